// File: doc/BRIEF.md
# Hardware Thread Context Scheduler

This block keeps track of eight hardware thread contexts that share one execution engine. Every context holds a lifecycle state (Inactive, Ready, Executing, Sleeping), a program counter, an arrived-signals mask and a wakeup mask. Software reaches the per-context registers indirectly: it first writes a context selector, and then the status, signal and wakeup registers at their fixed offsets act on the selected context. A shared enable register decides which contexts may move from Ready to Executing. When the engine is idle, a round-robin arbiter grants the next Ready and enabled context. The instruction datapath reports back through a yield request, which carries the resume program counter, and a kill request.

The enable bits only gate the next grant. A context that is already executing keeps the engine until it yields or is killed. A context is Ready whenever its arrived signals overlap its wakeup mask. Writing a 1 into both masks is therefore the usual way to make a freshly loaded context runnable.

Top module: `ctx_enable_ctrl`

## Requirements
- R1: After reset every context is Inactive with program counter 0 and both masks 0, the enable register and the selector read 0, the active-status register reads 0, and `run_valid` is low.
- R2: The selector (byte offset 0x020, bits 2:0) chooses the context addressed at offsets 0x040, 0x048 and 0x050. At 0x040 bits 11:0 are the program counter (read and write), bits 29:28 are the state (read only, 0 Inactive, 1 Ready, 2 Executing, 3 Sleeping), and all other bits read 0.
- R3: The enable register at offset 0x018 holds one bit per context in bits 15:8, with bit 8+i for context i. All other bits of that register are ignored on write and read 0.
- R4: Writing the wakeup mask (0x050) of an Inactive context so that it overlaps that context's signal mask (0x048) moves the context to Ready on the same clock edge. Writing only the signal mask leaves it Inactive.
- R5: At most one context is Executing. A context enters Executing only from Ready, only with its enable bit set, and only while no context is Executing. The grant takes effect one clock after those conditions hold.
- R6: Grants rotate round-robin. The search starts at the context after the one granted last, and after reset it starts at context 0.
- R7: Clearing the enable bit of the Executing context does not remove it from execution.
- R8: A yield moves the Executing context to Ready if its signal and wakeup masks overlap, and otherwise to Sleeping. Its program counter becomes `yield_pc`. `run_valid` is low on the clock after the yield.
- R9: The `ev_in` bits are ORed into every context's signal mask on each clock. A Sleeping context whose updated signals overlap its wakeup mask becomes Ready on that edge.
- R10: A kill returns the Executing context to Inactive and leaves its program counter unchanged. The context stays Inactive even if its masks overlap, until its wakeup mask is written again.
- R11: The active-status register (0x044) has bit 31 set while any context is Executing, with that context's index in bits 2:0. All other bits read 0, and it reads 0 when the engine is idle.
- R12: A write to the signal mask replaces it with the written value, which is ORed with `ev_in` in that same cycle. The mask reads back at 0x048 in bits 7:0, and so does the wakeup mask at 0x050.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 9 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` (combinational) |
| ev_in | input | 8 | Signal events broadcast to all contexts |
| yield_req | input | 1 | Executing context yields voluntarily |
| yield_pc | input | 12 | Resume program counter saved on yield |
| kill_req | input | 1 | Executing context terminates |
| run_valid | output | 1 | A context is Executing |
| run_ctx | output | 3 | Index of the Executing context |
| run_pc | output | 12 | Program counter of the Executing context |

## Verification
If a context's state is wrong, it shows at `run_ctx` at the next grant. The stuck context is skipped, granted out of turn, or granted while its enable bit is clear. The bench detects this two clocks after each yield, because it compares the grant with a rotation computed from the enable mask and the last granted index, for all 256 enable masks. A bad selector, mask or program-counter register shows up on the next indirect read. A lost no-preemption or kill rule shows up one clock later in `run_valid` and in the active-status register.

// File: rtl/mce_pkg.sv
// Shared types and register layout for the context scheduler.
// Assumes byte offsets on a 9-bit register address.
package mce_pkg;
    typedef enum logic [1:0] {
        CTX_INACTIVE = 2'd0,
        CTX_READY    = 2'd1,
        CTX_EXEC     = 2'd2,
        CTX_SLEEP    = 2'd3
    } ctx_state_e;

    localparam int CSR_AW = 9;
    localparam logic [CSR_AW-1:0] OFS_ENABLES = 9'h018;
    localparam logic [CSR_AW-1:0] OFS_CTX_SEL = 9'h020;
    localparam logic [CSR_AW-1:0] OFS_CTX_STS = 9'h040;
    localparam logic [CSR_AW-1:0] OFS_ACTIVE  = 9'h044;
    localparam logic [CSR_AW-1:0] OFS_SIG     = 9'h048;
    localparam logic [CSR_AW-1:0] OFS_WAKE    = 9'h050;

    localparam int EN_LSB     = 8;
    localparam int STATE_LSB  = 28;
    localparam int ACTIVE_BIT = 31;
endpackage

// File: rtl/mce_ctx_slot.sv
// One context: lifecycle state, program counter, signal and wakeup masks.
// Assumes yield_i/kill_i are only meaningful while this context executes;
// kill wins over yield; a hardware yield wins over a software PC write.
module mce_ctx_slot
    import mce_pkg::*;
#(
    parameter int PCW = 12,
    parameter int EVW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic           grant_i,
    input  logic           yield_i,
    input  logic           kill_i,
    input  logic [PCW-1:0] yield_pc_i,
    input  logic           pc_wr_i,
    input  logic           sig_wr_i,
    input  logic           wake_wr_i,
    input  logic [PCW-1:0] wdata_pc_i,
    input  logic [EVW-1:0] wdata_ev_i,
    input  logic [EVW-1:0] ev_i,
    output logic [1:0]     state_o,
    output logic [PCW-1:0] pc_o,
    output logic [EVW-1:0] sig_o,
    output logic [EVW-1:0] wake_o
);
    ctx_state_e     state_q, state_d;
    logic [PCW-1:0] pc_q;
    logic [EVW-1:0] sig_q, sig_d, wake_q, wake_d;
    logic           match_d;

    // Next mask values and their overlap, seen by the state update this cycle.
    always_comb begin
        sig_d   = (sig_wr_i ? wdata_ev_i : sig_q) | ev_i;
        wake_d  = wake_wr_i ? wdata_ev_i : wake_q;
        match_d = |(sig_d & wake_d);
    end

    // Lifecycle transitions.
    always_comb begin
        state_d = state_q;
        case (state_q)
            CTX_INACTIVE: if (wake_wr_i && match_d) state_d = CTX_READY;
            CTX_SLEEP:    if (match_d) state_d = CTX_READY;
            CTX_READY:    if (grant_i) state_d = CTX_EXEC;
            CTX_EXEC: begin
                if (kill_i)       state_d = CTX_INACTIVE;
                else if (yield_i) state_d = match_d ? CTX_READY : CTX_SLEEP;
            end
            default:      state_d = CTX_INACTIVE;
        endcase
    end

    // Register state, masks and program counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTX_INACTIVE;
            pc_q    <= '0;
            sig_q   <= '0;
            wake_q  <= '0;
        end else begin
            state_q <= state_d;
            sig_q   <= sig_d;
            wake_q  <= wake_d;
            if (state_q == CTX_EXEC && yield_i && !kill_i) pc_q <= yield_pc_i;
            else if (pc_wr_i)                              pc_q <= wdata_pc_i;
        end
    end

    assign state_o = state_q;
    assign pc_o    = pc_q;
    assign sig_o   = sig_q;
    assign wake_o  = wake_q;

    // R5: a disabled Ready context never starts executing.
    p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTX_READY && !en_i) |=> (state_q != CTX_EXEC));

    // R7: no preemption without yield or kill.
    p_no_preempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTX_EXEC && !yield_i && !kill_i) |=> (state_q == CTX_EXEC));

    // R10: kill lands in Inactive.
    p_kill_inactive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTX_EXEC && kill_i) |=> (state_q == CTX_INACTIVE));

    // R8: a yield always leaves Executing and saves the resume PC.
    p_yield_leaves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTX_EXEC && yield_i && !kill_i) |=>
            (state_q != CTX_EXEC && pc_q == $past(yield_pc_i)));
endmodule

// File: rtl/mce_rr_pick.sv
// Round-robin arbiter: grants one Ready and enabled context while the
// engine is idle, searching from the one after the last grant.
// Assumes the granted context enters Executing on the same edge.
module mce_rr_pick #(
    parameter int NCTX = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCTX-1:0] ready_i,
    input  logic [NCTX-1:0] en_i,
    input  logic            busy_i,
    output logic [NCTX-1:0] grant_o
);
    localparam int IDXW = (NCTX > 1) ? $clog2(NCTX) : 1;

    logic [IDXW-1:0] last_q, pick_idx;
    logic            found;

    // Rotating search for the first eligible context after last_q.
    always_comb begin
        grant_o  = '0;
        found    = 1'b0;
        pick_idx = last_q;
        for (int off = 1; off <= NCTX; off++) begin
            int idx;
            idx = (int'(last_q) + off) % NCTX;
            if (!found && !busy_i && ready_i[idx] && en_i[idx]) begin
                found        = 1'b1;
                grant_o[idx] = 1'b1;
                pick_idx     = IDXW'(idx);
            end
        end
    end

    // Remember the last granted context; reset points just before context 0.
    always_ff @(posedge clk) begin
        if (!rst_n)     last_q <= IDXW'(NCTX - 1);
        else if (found) last_q <= pick_idx;
    end

    // R5: never a grant while a context executes.
    p_idle_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (grant_o == '0));
endmodule

// File: rtl/mce_csr_file.sv
// Register decode: enable mask, context selector, per-context write strobes
// and the read multiplexer. Assumes read data is combinational on address.
module mce_csr_file
    import mce_pkg::*;
#(
    parameter int NCTX = 8,
    parameter int PCW  = 12,
    parameter int EVW  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  csr_wr,
    input  logic [CSR_AW-1:0]     csr_addr,
    input  logic [31:0]           csr_wdata,
    output logic [31:0]           csr_rdata,
    output logic [NCTX-1:0]       en_o,
    output logic [NCTX-1:0]       pc_wr_o,
    output logic [NCTX-1:0]       sig_wr_o,
    output logic [NCTX-1:0]       wake_wr_o,
    input  logic [NCTX*2-1:0]     state_flat_i,
    input  logic [NCTX*PCW-1:0]   pc_flat_i,
    input  logic [NCTX*EVW-1:0]   sig_flat_i,
    input  logic [NCTX*EVW-1:0]   wake_flat_i,
    input  logic                  run_valid_i,
    input  logic [$clog2(NCTX)-1:0] run_ctx_i
);
    localparam int IDXW = $clog2(NCTX);

    logic [NCTX-1:0] en_q;
    logic [IDXW-1:0] sel_q;
    logic            unused_wbits;

    assign unused_wbits = ^csr_wdata;

    // Global enable mask and context selector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            sel_q <= '0;
        end else if (csr_wr) begin
            if (csr_addr == OFS_ENABLES) en_q  <= csr_wdata[EN_LSB +: NCTX];
            if (csr_addr == OFS_CTX_SEL) sel_q <= csr_wdata[IDXW-1:0];
        end
    end

    // Per-context write strobes for the indirect registers.
    always_comb begin
        pc_wr_o   = '0;
        sig_wr_o  = '0;
        wake_wr_o = '0;
        pc_wr_o[sel_q]   = csr_wr && (csr_addr == OFS_CTX_STS);
        sig_wr_o[sel_q]  = csr_wr && (csr_addr == OFS_SIG);
        wake_wr_o[sel_q] = csr_wr && (csr_addr == OFS_WAKE);
    end

    // Read multiplexer.
    always_comb begin
        csr_rdata = '0;
        case (csr_addr)
            OFS_ENABLES: csr_rdata[EN_LSB +: NCTX] = en_q;
            OFS_CTX_SEL: csr_rdata[IDXW-1:0] = sel_q;
            OFS_CTX_STS: begin
                csr_rdata[PCW-1:0]            = pc_flat_i[sel_q*PCW +: PCW];
                csr_rdata[STATE_LSB +: 2]     = state_flat_i[sel_q*2 +: 2];
            end
            OFS_ACTIVE: begin
                csr_rdata[ACTIVE_BIT] = run_valid_i;
                csr_rdata[IDXW-1:0]   = run_valid_i ? run_ctx_i : '0;
            end
            OFS_SIG:  csr_rdata[EVW-1:0] = sig_flat_i[sel_q*EVW +: EVW];
            OFS_WAKE: csr_rdata[EVW-1:0] = wake_flat_i[sel_q*EVW +: EVW];
            default:  csr_rdata = '0;
        endcase
    end

    assign en_o = en_q;
endmodule

// File: rtl/ctx_enable_ctrl.sv
// Top: eight context slots, a round-robin arbiter and the register file.
// Assumes yield_req/kill_req are driven only while run_valid is high.
module ctx_enable_ctrl
    import mce_pkg::*;
#(
    parameter int NCTX = 8,
    parameter int PCW  = 12,
    parameter int EVW  = 8,
    localparam int IDXW = $clog2(NCTX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    input  logic [EVW-1:0]    ev_in,
    input  logic              yield_req,
    input  logic [PCW-1:0]    yield_pc,
    input  logic              kill_req,
    output logic              run_valid,
    output logic [IDXW-1:0]   run_ctx,
    output logic [PCW-1:0]    run_pc
);
    logic [NCTX-1:0]     en, pc_wr, sig_wr, wake_wr, grant, ready_vec, exec_vec;
    logic [NCTX*2-1:0]   state_flat;
    logic [NCTX*PCW-1:0] pc_flat;
    logic [NCTX*EVW-1:0] sig_flat, wake_flat;

    mce_csr_file #(.NCTX(NCTX), .PCW(PCW), .EVW(EVW)) u_csr (
        .clk(clk), .rst_n(rst_n),
        .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata),
        .en_o(en), .pc_wr_o(pc_wr), .sig_wr_o(sig_wr), .wake_wr_o(wake_wr),
        .state_flat_i(state_flat), .pc_flat_i(pc_flat),
        .sig_flat_i(sig_flat), .wake_flat_i(wake_flat),
        .run_valid_i(run_valid), .run_ctx_i(run_ctx)
    );

    for (genvar i = 0; i < NCTX; i++) begin : g_slot
        mce_ctx_slot #(.PCW(PCW), .EVW(EVW)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .en_i(en[i]), .grant_i(grant[i]),
            .yield_i(yield_req && exec_vec[i]), .kill_i(kill_req && exec_vec[i]),
            .yield_pc_i(yield_pc),
            .pc_wr_i(pc_wr[i]), .sig_wr_i(sig_wr[i]), .wake_wr_i(wake_wr[i]),
            .wdata_pc_i(csr_wdata[PCW-1:0]), .wdata_ev_i(csr_wdata[EVW-1:0]),
            .ev_i(ev_in),
            .state_o(state_flat[i*2 +: 2]), .pc_o(pc_flat[i*PCW +: PCW]),
            .sig_o(sig_flat[i*EVW +: EVW]), .wake_o(wake_flat[i*EVW +: EVW])
        );
        assign ready_vec[i] = (state_flat[i*2 +: 2] == CTX_READY);
        assign exec_vec[i]  = (state_flat[i*2 +: 2] == CTX_EXEC);
    end

    mce_rr_pick #(.NCTX(NCTX)) u_pick (
        .clk(clk), .rst_n(rst_n),
        .ready_i(ready_vec), .en_i(en), .busy_i(run_valid), .grant_o(grant)
    );

    // Encode the executing context and expose its program counter.
    always_comb begin
        run_valid = |exec_vec;
        run_ctx   = '0;
        run_pc    = '0;
        for (int i = 0; i < NCTX; i++) begin
            if (exec_vec[i]) begin
                run_ctx = IDXW'(i);
                run_pc  = pc_flat[i*PCW +: PCW];
            end
        end
    end

    // R5: at most one context executes.
    p_single_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(exec_vec));

    // R8: the engine is idle on the clock after a yield or kill.
    p_yield_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_valid && (yield_req || kill_req)) |=> !run_valid);
endmodule

// File: tb/ctx_enable_ctrl_test.sv
module ctx_enable_ctrl_test;
    localparam int NCTX = 8;
    localparam int PCW  = 12;
    localparam int EVW  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [8:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [7:0]  ev_in = '0;
    logic        yield_req = 1'b0;
    logic [11:0] yield_pc = '0;
    logic        kill_req = 1'b0;
    logic        run_valid;
    logic [2:0]  run_ctx;
    logic [11:0] run_pc;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Model of the arbiter rotation.
    int m_last = NCTX - 1;
    bit m_run  = 0;
    int m_cur  = 0;

    always #10 clk = ~clk;

    ctx_enable_ctrl #(.NCTX(NCTX), .PCW(PCW), .EVW(EVW)) uut (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .ev_in(ev_in),
        .yield_req(yield_req), .yield_pc(yield_pc), .kill_req(kill_req),
        .run_valid(run_valid), .run_ctx(run_ctx), .run_pc(run_pc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    function automatic int next_pick(input int mask, input int last);
        for (int off = 1; off <= NCTX; off++) begin
            int idx;
            idx = (last + off) % NCTX;
            if (mask[idx]) return idx;
        end
        return -1;
    endfunction

    // Yield at the next negedge; sample two edges later.
    task automatic do_yield(input logic [11:0] pc);
        @(negedge clk);
        yield_req = 1'b1; yield_pc = pc;
        @(negedge clk);
        yield_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1 check("R1 run_valid", {31'b0, run_valid}, 32'd0);
        rd(9'h018, d); check("R1 enables", d, 32'd0);
        rd(9'h020, d); check("R1 selector", d, 32'd0);
        rd(9'h044, d); check("R1 active", d, 32'd0);
        for (int i = 0; i < NCTX; i++) begin
            wr(9'h020, i);
            rd(9'h040, d); check("R1 status", d, 32'd0);
            rd(9'h048, d); check("R1 sig", d, 32'd0);
            rd(9'h050, d); check("R1 wake", d, 32'd0);
        end

        // R2: indirect PC write then readback of all contexts
        for (int i = 0; i < NCTX; i++) begin
            wr(9'h020, i);
            wr(9'h040, 32'hFFFF_F000 | (32'h100 + i * 7));
        end
        for (int i = 0; i < NCTX; i++) begin
            wr(9'h020, i);
            rd(9'h040, d); check("R2 pc/state", d, 32'h100 + i * 7);
        end

        // R4: signal write alone keeps context 3 Inactive; wakeup overlap readies it
        wr(9'h020, 3);
        wr(9'h048, 32'h1);
        rd(9'h040, d); check("R4 still inactive", d[29:28], 32'd0);
        wr(9'h050, 32'h1);
        rd(9'h040, d); check("R4 ready", d[29:28], 32'd1);
        rd(9'h050, d); check("R12 wake readback", d, 32'h1);

        // R12: ev_in ORs into signals
        @(negedge clk); ev_in = 8'h80;
        @(negedge clk); ev_in = 8'h00;
        rd(9'h048, d); check("R12 sig or", d, 32'h81);

        // R3/R5: enable context 3 only (with junk bits); it runs
        wr(9'h018, 32'hA5A5_08A5);
        @(negedge clk);
        check("R5 run_valid", {31'b0, run_valid}, 32'd1);
        check("R5 run_ctx", {29'b0, run_ctx}, 32'd3);
        check("R5 run_pc", {20'b0, run_pc}, 32'h100 + 3 * 7);
        rd(9'h018, d); check("R3 enables", d, 32'h0000_0800);
        rd(9'h044, d); check("R11 active", d, 32'h8000_0003);
        rd(9'h040, d); check("R2 exec code", d[29:28], 32'd2);

        // R8: clear signals, yield -> Sleeping, PC saved
        wr(9'h048, 32'h0);
        do_yield(12'h02A);
        check("R8 idle after yield", {31'b0, run_valid}, 32'd0);
        rd(9'h040, d); check("R8 sleeping+pc", d, 32'h3000_002A);
        rd(9'h044, d); check("R11 idle", d, 32'd0);

        // R9: event wakes the sleeper, which is granted again
        @(negedge clk); ev_in = 8'h01;
        @(negedge clk); ev_in = 8'h00;
        @(negedge clk);
        check("R9 woken and run", {28'b0, run_valid, run_ctx}, {28'b0, 1'b1, 3'd3});

        // R10: kill -> Inactive, stays Inactive despite overlapping masks
        @(negedge clk); kill_req = 1'b1;
        @(negedge clk); kill_req = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 idle", {31'b0, run_valid}, 32'd0);
        rd(9'h040, d); check("R10 inactive pc kept", d, 32'h0000_002A);
        m_last = 3;

        // Sweep setup: all enables off, all contexts Ready
        wr(9'h018, 32'h0);
        for (int i = 0; i < NCTX; i++) begin
            wr(9'h020, i);
            wr(9'h048, 32'h1);
            wr(9'h050, 32'h1);
        end
        wr(9'h020, 0);
        rd(9'h040, d); check("R4 ctx0 ready", d[29:28], 32'd1);
        check("R5 none enabled", {31'b0, run_valid}, 32'd0);

        // R6/R7/R3: every enable mask, then three yields
        for (int m = 0; m < 256; m++) begin
            wr(9'h018, 32'h5A5A_005A | (m << 8));
            @(negedge clk);
            if (!m_run) begin
                int p;
                p = next_pick(m, m_last);
                if (p >= 0) begin m_run = 1; m_cur = p; m_last = p; end
            end else if (!m[m_cur]) begin
                check("R7 no preempt", {28'b0, run_valid, run_ctx}, {28'b0, 1'b1, 3'(m_cur)});
            end
            check("R6 grant after enable", {28'b0, run_valid, run_ctx},
                  {28'b0, m_run, m_run ? 3'(m_cur) : 3'd0});
            rd(9'h018, d); check("R3 enables", d, m << 8);
            for (int y = 0; y < 3; y++) begin
                if (m_run) begin
                    int p;
                    do_yield(12'(m));
                    p = next_pick(m, m_last);
                    m_run = (p >= 0);
                    if (m_run) begin m_cur = p; m_last = p; end
                    check("R6 rotation", {28'b0, run_valid, run_ctx},
                          {28'b0, m_run, m_run ? 3'(m_cur) : 3'd0});
                    if (m_run) begin
                        rd(9'h044, d); check("R11 active index", d, 32'h8000_0000 | m_cur);
                    end
                end
            end
        end
        finish_run();
    end
endmodule